// File: doc/BRIEF.md
# Segment Limit Check and Translation

This block is one registered stage of a segmented address path. Each cycle it may take a segment descriptor that has already been loaded and a logical offset, marked by an input strobe. The descriptor supplies a 32-bit base, a 20-bit limit, a granularity flag and a code default-size flag.

The stage first decides the access width, either 16 or 32 bits. It builds an effective 32-bit limit from the 20-bit field. It checks that every byte of the access lies inside that limit. One clock later it reports one of two results: the linear address (base plus offset), or a limit fault. The granularity flag lets a single descriptor format span either a byte-counted segment of up to 1 MB or a page-counted segment of up to 4 GB.

Fetching descriptor tables, privilege rules, paging and fault handling are left to surrounding logic.

Top module: `seg_xlate`

## Requirements
- R1: While `rst` is high, at the next clock edge `out_valid`, `fault`, `lin_addr` and `eff32` all become 0.
- R2: With `gran` = 0 the effective limit is `limit` zero-extended to 32 bits, counted in bytes. With limit 0xFFFFF, a 1-byte access at offset 0xFFFFF is legal and a 2-byte access at that offset faults.
- R3: With `gran` = 1 the effective limit is `limit` followed by twelve 1 bits, counted in 4096-byte pages. With limit 0xFFFFF, every offset up to 0xFFFFFFFF is legal for a 1-byte access.
- R4: `acc_len` selects the access width: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. An access of N bytes at offset O faults when O+N-1, computed without wrap, exceeds the effective limit. For example, a 4-byte access at 0xFFFFFFFD faults even under a 4 GB limit.
- R5: `eff32` reports the effective size (1 = 32-bit, 0 = 16-bit), equal to `def32` XOR `size_ovr` of the accepted request.
- R6: When the effective size is 16-bit, only the low 16 bits of `offset` are used, both for the limit check and for the address sum.
- R7: For a legal access `lin_addr` = `base` + offset, modulo 2^32. Whenever `fault` is 1, `lin_addr` is 0.
- R8: `out_valid` is 1 exactly one cycle after a cycle with `in_valid` high, and `fault` is only ever 1 together with `out_valid`.
- R9: After a cycle with `in_valid` low, `out_valid` and `fault` are 0 while `lin_addr` and `eff32` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| base | input | 32 | Segment base |
| limit | input | 20 | Segment limit field |
| gran | input | 1 | Limit units: 0 bytes, 1 pages of 4096 bytes |
| def32 | input | 1 | Segment default size: 1 = 32-bit |
| size_ovr | input | 1 | Flip the size for this access |
| acc_len | input | 2 | Access width code (see R4) |
| offset | input | 32 | Logical offset |
| out_valid | output | 1 | Result valid |
| fault | output | 1 | Limit violation |
| lin_addr | output | 32 | Linear address |
| eff32 | output | 1 | Effective size, 1 = 32-bit |

## Verification
Every result appears exactly one clock after the edge that captures the request: valid, fault, address and size all come from a single register stage. The bench changes inputs on the falling edge. At each following falling edge it compares all four outputs against a behavioural model that it advanced when it drove those inputs. In this way each check lands on the cycle in which the captured request is shown. Idle cycles and reset cycles are handled by the same model, so checks of held values and cleared values fall on the correct edge as well.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW = 32,
  parameter int LW = 20,
  parameter int PG = 12,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] limit,
  input  logic          gran,
  input  logic          def32,
  input  logic          size_ovr,
  input  logic [1:0]    acc_len,
  input  logic [AW-1:0] offset,
  output logic          out_valid,
  output logic          fault,
  output logic [AW-1:0] lin_addr,
  output logic          eff32
);
  localparam int XW = AW - LW;
  localparam int TW = AW - SW;

  logic          wide;
  logic [AW-1:0] off_use;
  logic [AW-1:0] lim_eff;
  logic [AW:0]   last_byte;
  logic [AW-1:0] extra;
  logic          bad;

  assign wide    = def32 ^ size_ovr;
  assign off_use = wide ? offset : {{TW{1'b0}}, offset[SW-1:0]};
  assign lim_eff = gran ? {limit, {PG{1'b1}}} : {{XW{1'b0}}, limit};
  assign extra   = (acc_len == 2'd0) ? '0 :
                   (acc_len == 2'd1) ? AW'(1) : AW'(3);
  assign last_byte = {1'b0, off_use} + {1'b0, extra};
  assign bad       = last_byte > {1'b0, lim_eff};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      fault     <= 1'b0;
      lin_addr  <= '0;
      eff32     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      fault     <= in_valid & bad;
      if (in_valid) begin
        lin_addr <= bad ? '0 : base + off_use;
        eff32    <= wide;
      end
    end
  end

  // R8
  fault_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> out_valid);

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  no_addr_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> lin_addr == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !fault && $stable(lin_addr) && $stable(eff32)));

  // R5
  size_sel_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> eff32 == ($past(def32) ^ $past(size_ovr)));
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam time TCK = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] base = '0;
  logic [19:0] limit = '0;
  logic        gran = 1'b0;
  logic        def32 = 1'b0;
  logic        size_ovr = 1'b0;
  logic [1:0]  acc_len = '0;
  logic [31:0] offset = '0;
  logic        out_valid, fault, eff32;
  logic [31:0] lin_addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic        e_valid = 1'b0, e_fault = 1'b0, e_eff32 = 1'b0;
  logic [31:0] e_addr = '0;
  bit          e_known = 1'b0;

  always #(TCK/2) clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base(base), .limit(limit),
    .gran(gran), .def32(def32), .size_ovr(size_ovr), .acc_len(acc_len),
    .offset(offset), .out_valid(out_valid), .fault(fault),
    .lin_addr(lin_addr), .eff32(eff32)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    if (!e_known) return;
    chk(out_valid === e_valid, {tag, " R8 out_valid"}, longint'(out_valid), longint'(e_valid));
    chk(fault === e_fault, {tag, " R4 fault"}, longint'(fault), longint'(e_fault));
    chk(lin_addr === e_addr, {tag, " R7 lin_addr"}, longint'(lin_addr), longint'(e_addr));
    chk(eff32 === e_eff32, {tag, " R5 eff32"}, longint'(eff32), longint'(e_eff32));
  endtask

  task automatic model();
    longint n, o, lim;
    bit w, b;
    if (rst) begin
      e_valid = 0; e_fault = 0; e_addr = 0; e_eff32 = 0; e_known = 1;
      return;
    end
    e_valid = in_valid;
    if (!in_valid) begin
      e_fault = 0;
      return;
    end
    w = def32 ^ size_ovr;
    n = (acc_len == 0) ? 1 : (acc_len == 1) ? 2 : 4;
    o = w ? longint'(offset) : longint'(offset[15:0]);
    lim = gran ? longint'(limit) * 4096 + 4095 : longint'(limit);
    b = (o + n - 1) > lim;
    e_fault = b;
    e_eff32 = w;
    e_addr = b ? 32'h0 : 32'((longint'(base) + o) % 64'h1_0000_0000);
  endtask

  task automatic step(input string tag, input bit v, input logic [31:0] bs,
                      input logic [19:0] lm, input bit g, input bit d,
                      input bit ov, input logic [1:0] len, input logic [31:0] off);
    @(negedge clk);
    compare(tag);
    in_valid = v; base = bs; limit = lm; gran = g; def32 = d;
    size_ovr = ov; acc_len = len; offset = off;
    model();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) cyc++;

  initial begin
    // R1: reset with a valid request present
    rst = 1'b1;
    step("R1 reset", 1, 32'h1000, 20'hFFFFF, 1, 1, 0, 2, 32'h10);
    step("R1 reset", 1, 32'h1000, 20'hFFFFF, 1, 1, 0, 2, 32'h10);
    @(negedge clk);
    compare("R1 reset");
    rst = 1'b0;
    model();
    // R2: byte granularity 1 MB boundary
    step("R2", 1, 32'h0010_0000, 20'hFFFFF, 0, 1, 0, 0, 32'h000F_FFFF);
    step("R2", 1, 32'h0010_0000, 20'hFFFFF, 0, 1, 0, 1, 32'h000F_FFFF);
    step("R2", 1, 32'h0010_0000, 20'hFFFFF, 0, 1, 0, 0, 32'h0010_0000);
    // R3: page granularity, 4 GB and last page bytes
    step("R3", 1, 32'h0, 20'hFFFFF, 1, 1, 0, 0, 32'hFFFF_FFFF);
    step("R3", 1, 32'h0, 20'h00000, 1, 1, 0, 0, 32'h0000_0FFF);
    step("R3", 1, 32'h0, 20'h00000, 1, 1, 0, 0, 32'h0000_1000);
    // R4: widths and no wrap
    step("R4", 1, 32'h0, 20'hFFFFF, 1, 1, 0, 2, 32'hFFFF_FFFD);
    step("R4", 1, 32'h0, 20'hFFFFF, 1, 1, 0, 3, 32'hFFFF_FFFC);
    step("R4", 1, 32'h0, 20'h00010, 0, 1, 0, 1, 32'h0000_000F);
    step("R4", 1, 32'h0, 20'h00010, 0, 1, 0, 2, 32'h0000_000D);
    // R5/R6: size override and 16-bit truncation
    step("R6", 1, 32'h0002_0000, 20'h0FFFF, 0, 0, 0, 0, 32'h1234_FFFF);
    step("R6", 1, 32'h0002_0000, 20'h0FFFF, 0, 0, 0, 1, 32'h1234_FFFF);
    step("R5", 1, 32'h0002_0000, 20'h0FFFF, 0, 1, 1, 0, 32'h1234_0010);
    step("R5", 1, 32'h0002_0000, 20'hFFFFF, 1, 0, 1, 0, 32'h1234_0010);
    // R7: base wrap
    step("R7", 1, 32'hFFFF_FF00, 20'hFFFFF, 1, 1, 0, 2, 32'h0000_0200);
    // R9: idle with disturbed inputs
    step("R9", 0, 32'h5555_5555, 20'h0, 0, 0, 0, 3, 32'hFFFF_FFFF);
    step("R9", 0, 32'hAAAA_AAAA, 20'h1, 1, 1, 1, 0, 32'h0);
    step("R8", 1, 32'h10, 20'h0, 0, 1, 0, 2, 32'h0);
    step("R8", 0, 32'h10, 20'h0, 0, 1, 0, 2, 32'h0);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [19:0] lm;
      lm = ($urandom % 4 == 0) ? 20'hFFFFF : 20'($urandom);
      step("mix", ($urandom % 5) != 0, $urandom, lm, 1'($urandom),
           1'($urandom), 1'($urandom), 2'($urandom),
           ($urandom % 2) ? {12'h0, lm} + 32'($urandom % 8) - 32'd4 : $urandom);
    end
    step("end", 0, 0, 0, 0, 0, 0, 0, 0);
    step("end", 0, 0, 0, 0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule